// File: doc/BRIEF.md
# Dual-Rail Precharge/Evaluate Pipeline

This block is a cycle-level, synthesizable model of a latch-free asynchronous pipeline built from dual-rail stages. Each stage alternates between a precharge phase, in which it drives an all-zero spacer, and an evaluate phase, in which it turns a complete input word into a valid dual-rail output word and keeps it. A stage has no storage apart from this evaluated state. Its only control wire is the completion signal of the stage after it: while that signal is high the stage precharges, and while it is low the stage evaluates. The completion detector of stage 0 goes back to the producer as an acknowledge. The last stage takes its control from a consumer acknowledge.

Each handshake event (one evaluation, one precharge or one completion detection) costs one clock step. Tokens flow in order and are always separated by spacers. Each stage applies a fixed transform to the word, either identity or increment, chosen per stage by a mask parameter.

Every stage is a three-state machine. The states are ST_PRE (precharged, spacer out), ST_WAIT (evaluating, input incomplete, spacer out) and ST_HOLD (evaluating, valid token out). The transitions are T_PRECHARGE (any state to ST_PRE while control is high), T_ARM (ST_PRE to ST_WAIT while control is low and the input is incomplete), T_CAPTURE (ST_PRE or ST_WAIT to ST_HOLD while control is low and every input bit is valid) and T_KEEP (stay in ST_HOLD while control is low). Each completion detector is a two-state machine, DN_LOW and DN_HIGH. The transition T_RISE fires when all bits are valid and T_FALL fires when all bits are zero; in every other case the detector holds.

Top module: `dr_pipe`

## Requirements
- R1: Bit i of a word travels on a true rail and a false rail (`*_tru[i]`, `*_fal[i]`). True high with false low encodes 1. False high with true low encodes 0. Both rails low is a spacer. Both rails high is never presented.
- R2: Synchronous reset (`rst` high at a clock edge) puts every stage into precharge. After reset, `out_tru`, `out_fal` and `in_done` are all 0.
- R3: While any input bit is still a spacer, an evaluating stage keeps its spacer output. A partially valid input word therefore leaves `in_done` low and the output at spacer.
- R4: If a token is presented to an empty pipeline before clock edge e, stage 0 captures it at e, and each later stage captures it one edge after its predecessor. The token appears on the output after edge e+NS-1.
- R5: A stage's done signal rises one step after all of its output bits become valid and falls one step after all of them return to zero. Otherwise it holds. `in_done` is stage 0's done, so it goes high two edges after the producer presents a token to an empty pipeline.
- R6: A stage precharges (spacer on the next step) when the done signal of the next stage is high. For the last stage, that signal is `out_ack`. While its control stays low, a stage holding a token keeps it stable.
- R7: A stage evaluates only while the next stage's done signal is low. Tokens leave in the order they were accepted, with none lost or repeated.
- R8: Two adjacent stages that both hold valid words hold the same token. When the consumer never acknowledges, the block accepts exactly NS/2 tokens and refuses the next one (`in_done` stays low).
- R9: With a producer and a consumer that respond promptly, one token leaves every 6 clock steps in steady state.
- R10: Stage k adds 1 modulo 2^W when bit k of `INC_MASK` is set and passes the word unchanged otherwise. The output value is therefore the input plus the number of set mask bits, modulo 2^W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one handshake event per edge |
| rst | input | 1 | Synchronous active-high reset |
| in_tru | input | W | True rails of the incoming word |
| in_fal | input | W | False rails of the incoming word |
| in_done | output | 1 | Stage 0 completion; producer acknowledge |
| out_tru | output | W | True rails of the outgoing word |
| out_fal | output | W | False rails of the outgoing word |
| out_ack | input | 1 | Consumer acknowledge; precharge control of the last stage |

## Verification
The assertions assume that the environment follows the same four-phase discipline as a neighbouring stage. The producer never drives both rails of a bit high. It presents a new word only after `in_done` has fallen, and it returns to spacer only after `in_done` has risen. The consumer raises `out_ack` only two steps after the output becomes valid, and lowers it only two steps after the output returns to spacer, which is the delay a real following stage would add. The bench producer waits on `in_done` at each phase. The bench consumer runs the output through a two-register completion model, so it can never take the same token twice. The stall scenario freezes this consumer with its acknowledge low, which stays inside the same rules.

// File: rtl/dr_pipe_pkg.sv
package dr_pipe_pkg;

    typedef enum logic [1:0] {
        ST_PRE  = 2'd0,
        ST_WAIT = 2'd1,
        ST_HOLD = 2'd2
    } stage_state_e;

    typedef enum logic {
        DN_LOW  = 1'b0,
        DN_HIGH = 1'b1
    } done_state_e;

    typedef enum logic {
        OP_PASS = 1'b0,
        OP_INC  = 1'b1
    } stage_op_e;

endpackage

// File: rtl/dr_xform.sv
module dr_xform
    import dr_pipe_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter stage_op_e   OP = OP_PASS
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);

    generate
        if (OP == OP_INC) begin : g_inc
            assign y = a + W'(1);
        end else begin : g_pass
            assign y = a;
        end
    endgenerate

endmodule

// File: rtl/dr_done.sv
module dr_done
    import dr_pipe_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] rail_t,
    input  logic [W-1:0] rail_f,
    output logic         done
);

    logic [W-1:0] bit_seen;
    logic         all_valid;
    logic         all_zero;
    done_state_e  st_q;
    done_state_e  st_d;

    // per-bit OR of the two rails, then C-element style merge
    assign bit_seen  = rail_t | rail_f;
    assign all_valid = &bit_seen;
    assign all_zero  = ~|bit_seen;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DN_LOW:  if (all_valid) st_d = DN_HIGH;   // T_RISE
            DN_HIGH: if (all_zero)  st_d = DN_LOW;    // T_FALL
            default: st_d = DN_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= DN_LOW;
        else     st_q <= st_d;
    end

    always_comb begin
        done = (st_q == DN_HIGH);
    end

    // R5: done rises only after a complete word, falls only after a full spacer
    a_r5_rise_on_valid: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(&(rail_t | rail_f)));
    a_r5_fall_on_spacer: assert property (@(posedge clk) disable iff (rst)
        $fell(done) |-> $past(~|(rail_t | rail_f)));

endmodule

// File: rtl/dr_stage.sv
module dr_stage
    import dr_pipe_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter stage_op_e   OP = OP_PASS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ctl,
    input  logic [W-1:0] in_t,
    input  logic [W-1:0] in_f,
    output logic [W-1:0] out_t,
    output logic [W-1:0] out_f
);

    stage_state_e st_q;
    stage_state_e st_d;
    logic [W-1:0] word_q;
    logic [W-1:0] word_fx;
    logic         in_complete;
    logic         capture;

    assign in_complete = &(in_t ^ in_f);

    dr_xform #(.W(W), .OP(OP)) u_fx (
        .a (in_t),
        .y (word_fx)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_PRE, ST_WAIT: begin
                if (ctl)              st_d = ST_PRE;    // T_PRECHARGE
                else if (in_complete) st_d = ST_HOLD;   // T_CAPTURE
                else                  st_d = ST_WAIT;   // T_ARM
            end
            ST_HOLD: begin
                if (ctl) st_d = ST_PRE;                 // T_PRECHARGE
                else     st_d = ST_HOLD;                // T_KEEP
            end
            default: st_d = ST_PRE;
        endcase
    end

    assign capture = (st_q != ST_HOLD) && (st_d == ST_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_PRE;
            word_q <= '0;
        end else begin
            st_q <= st_d;
            if (capture) word_q <= word_fx;
        end
    end

    always_comb begin
        if (st_q == ST_HOLD) begin
            out_t = word_q;
            out_f = ~word_q;
        end else begin
            out_t = '0;
            out_f = '0;
        end
    end

    // R6: precharge control seen high forces spacer on the next step
    a_r6_precharge: assert property (@(posedge clk) disable iff (rst)
        $past(ctl) |-> (~|(out_t | out_f)));
    // R6: a held token stays stable
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
        ((&(out_t ^ out_f)) && $past(&(out_t ^ out_f))) |-> ($stable(out_t) && $stable(out_f)));
    // R3: incomplete input keeps a spacer stage at spacer
    a_r3_no_early_eval: assert property (@(posedge clk) disable iff (rst)
        ($past(~|(out_t | out_f)) && !$past(&(in_t ^ in_f))) |-> (~|(out_t | out_f)));
    // R7: a new token appears only after evaluate control and a complete input
    a_r7_capture_rule: assert property (@(posedge clk) disable iff (rst)
        $rose(&(out_t ^ out_f)) |-> ($past(!ctl) && $past(&(in_t ^ in_f))));

endmodule

// File: rtl/dr_pipe.sv
module dr_pipe
    import dr_pipe_pkg::*;
#(
    parameter int unsigned      NS       = 4,
    parameter int unsigned      W        = 8,
    parameter logic [NS-1:0]    INC_MASK = NS'(5)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] in_tru,
    input  logic [W-1:0] in_fal,
    output logic         in_done,
    output logic [W-1:0] out_tru,
    output logic [W-1:0] out_fal,
    input  logic         out_ack
);

    localparam int unsigned NRAIL = NS + 1;

    logic [W-1:0] rt [NRAIL];
    logic [W-1:0] rf [NRAIL];
    logic [NS-1:0] done;
    logic [NS-1:0] ctl;

    assign rt[0]   = in_tru;
    assign rf[0]   = in_fal;
    assign out_tru = rt[NS];
    assign out_fal = rf[NS];
    assign in_done = done[0];

    generate
        for (genvar k = 0; k < NS; k++) begin : g_stage
            localparam stage_op_e OPK = INC_MASK[k] ? OP_INC : OP_PASS;

            if (k == NS - 1) begin : g_last
                assign ctl[k] = out_ack;
            end else begin : g_mid
                assign ctl[k] = done[k+1];
            end

            dr_stage #(.W(W), .OP(OPK)) u_stage (
                .clk   (clk),
                .rst   (rst),
                .ctl   (ctl[k]),
                .in_t  (rt[k]),
                .in_f  (rf[k]),
                .out_t (rt[k+1]),
                .out_f (rf[k+1])
            );

            dr_done #(.W(W)) u_done (
                .clk    (clk),
                .rst    (rst),
                .rail_t (rt[k+1]),
                .rail_f (rf[k+1]),
                .done   (done[k])
            );

            // R8: two adjacent valid stages carry one and the same token
            if (k < NS - 1) begin : g_adj
                logic [W-1:0] nxt_of_k;
                assign nxt_of_k = INC_MASK[k+1] ? (rt[k+1] + W'(1)) : rt[k+1];
                a_r8_adjacent_same: assert property (@(posedge clk) disable iff (rst)
                    ((&(rt[k+1] ^ rf[k+1])) && (&(rt[k+2] ^ rf[k+2])))
                        |-> (rt[k+2] == nxt_of_k));
            end
        end
    endgenerate

    // R1: environment never drives both rails of one bit high
    a_r1_input_legal: assert property (@(posedge clk) disable iff (rst)
        ~|(in_tru & in_fal));
    // R1: output rails are either a spacer or a complete complementary word
    a_r1_output_form: assert property (@(posedge clk) disable iff (rst)
        (~|(out_tru | out_fal)) || (out_fal == ~out_tru));

endmodule

// File: tb/dr_pipe_test.sv
module dr_pipe_test;

    localparam int NS = 4;
    localparam int W  = 8;
    localparam logic [NS-1:0] MASK = 4'b0101;
    localparam int ADD = $countones(MASK);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] in_tru = '0;
    logic [W-1:0] in_fal = '0;
    logic         in_done;
    logic [W-1:0] out_tru;
    logic [W-1:0] out_fal;
    logic         out_ack = 1'b0;

    always #2 clk = ~clk;

    dr_pipe #(.NS(NS), .W(W), .INC_MASK(MASK)) uut (
        .clk     (clk),
        .rst     (rst),
        .in_tru  (in_tru),
        .in_fal  (in_fal),
        .in_done (in_done),
        .out_tru (out_tru),
        .out_fal (out_fal),
        .out_ack (out_ack)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad   = 0;
    logic [W-1:0] expq [64];
    int arr_cyc [64];
    int wr = 0;
    int rd = 0;
    logic [W-1:0] lastv = '0;
    logic cons_hold = 1'b0;
    logic c1 = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // output monitor: order and value of every token leaving (R7, R10, R1)
    initial begin
        logic prev_v;
        logic v;
        prev_v = 1'b0;
        forever begin
            @(negedge clk);
            v = (&(out_tru ^ out_fal)) && !rst;
            if (v && !prev_v) begin
                if (rd < wr) begin
                    chk(out_tru == expq[rd % 64], "R7", "token value/order",
                        int'(out_tru), int'(expq[rd % 64]));
                end else begin
                    chk(1'b0, "R7", "unexpected token", int'(out_tru), -1);
                end
                chk(out_fal == ~out_tru, "R1", "false rails", int'(out_fal), int'(~out_tru));
                arr_cyc[rd % 64] = cyc;
                lastv = out_tru;
                rd++;
            end
            prev_v = v;
        end
    end

    // consumer: two-step completion model, like a following stage
    initial begin
        logic na;
        forever begin
            @(negedge clk);
            if (!cons_hold) begin
                na = c1;
                if (&(out_tru | out_fal))  c1 = 1'b1;
                else if (~|(out_tru | out_fal)) c1 = 1'b0;
                out_ack = na;
            end
        end
    end

    task automatic send(input logic [W-1:0] v, output int d, output int acc);
        @(negedge clk);
        while (in_done) @(negedge clk);
        in_tru = v;
        in_fal = ~v;
        expq[wr % 64] = v + W'(ADD);
        wr++;
        d = cyc;
        @(negedge clk);
        while (!in_done) @(negedge clk);
        acc = cyc - d;
        in_tru = '0;
        in_fal = '0;
    endtask

    task automatic wait_idle();
        while (rd < wr) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_tru == '0, "R2", "out_tru in reset", int'(out_tru), 0);
        chk(out_fal == '0, "R2", "out_fal in reset", int'(out_fal), 0);
        chk(in_done == 1'b0, "R2", "in_done in reset", int'(in_done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk((out_tru | out_fal) == '0, "R2", "spacer after reset", int'(out_tru | out_fal), 0);
    endtask

    task automatic t_single();
        int d;
        int acc;
        send(8'h05, d, acc);
        chk(acc == 2, "R5", "in_done delay", acc, 2);
        wait_idle();
        chk(arr_cyc[(rd - 1) % 64] - d == NS, "R4", "latency",
            arr_cyc[(rd - 1) % 64] - d, NS);
        chk(lastv == 8'h07, "R10", "transform sum", int'(lastv), 7);
    endtask

    task automatic t_stream();
        int d;
        int acc;
        int base;
        logic [W-1:0] v;
        base = rd;
        for (int k = 0; k < 10; k++) begin
            if (k == 0)      v = 8'hFF;
            else if (k == 1) v = 8'h00;
            else             v = W'(k * 53 + 7);
            send(v, d, acc);
        end
        wait_idle();
        chk(rd - base == 10, "R7", "token count", rd - base, 10);
        for (int i = base + 3; i < base + 10; i++) begin
            chk(arr_cyc[i % 64] - arr_cyc[(i - 1) % 64] == 6, "R9", "output spacing",
                arr_cyc[i % 64] - arr_cyc[(i - 1) % 64], 6);
        end
    endtask

    task automatic t_partial();
        int d;
        int acc;
        int seen;
        seen = 0;
        @(negedge clk);
        while (in_done) @(negedge clk);
        in_tru = 8'h05;
        in_fal = 8'h0A;
        repeat (8) begin
            @(negedge clk);
            if (in_done || (|(out_tru | out_fal))) seen++;
        end
        chk(seen == 0, "R3", "partial word accepted", seen, 0);
        in_tru = '0;
        in_fal = '0;
        send(8'hA5, d, acc);
        wait_idle();
        chk(lastv == 8'hA7, "R3", "word after completion", int'(lastv), int'(8'hA7));
    endtask

    task automatic t_stall();
        int d;
        int acc;
        int rises;
        int moved;
        int rd0;
        logic pd;
        rd0 = rd;
        cons_hold = 1'b1;
        send(8'h11, d, acc);
        send(8'h22, d, acc);
        @(negedge clk);
        while (in_done) @(negedge clk);
        in_tru = 8'h33;
        in_fal = ~8'h33;
        expq[wr % 64] = 8'h33 + W'(ADD);
        wr++;
        rises = 0;
        moved = 0;
        pd = in_done;
        repeat (40) begin
            @(negedge clk);
            if (in_done && !pd) rises++;
            pd = in_done;
        end
        repeat (10) begin
            @(negedge clk);
            if (out_tru != 8'h13 || out_fal != ~8'h13) moved++;
        end
        chk(rises == 0, "R8", "third token accepted while stalled", rises, 0);
        chk(rd - rd0 == 1, "R8", "tokens out while stalled", rd - rd0, 1);
        chk(moved == 0, "R6", "held output changed", moved, 0);
        cons_hold = 1'b0;
        @(negedge clk);
        while (!in_done) @(negedge clk);
        in_tru = '0;
        in_fal = '0;
        wait_idle();
        chk(rd - rd0 == 3, "R7", "tokens after release", rd - rd0, 3);
        chk(lastv == 8'h35, "R7", "last released token", int'(lastv), int'(8'h35));
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_single();
                t_stream();
                t_partial();
                t_stall();
            end
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL R7 watchdog: actual=%0d expected=%0d", wr - rd, 0);
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule